// File: doc/BRIEF.md
# Dual-Compare Combined PWM Generator

This block is a timer for one channel pair. It has a single counter, a reload register that fixes the period, and one compare register for each of the two channels. Each channel turns its compare value into a reference PWM waveform. A channel set to a combined code then merges its own reference with its partner's reference through OR or AND. Because one compare value places the rising edge and the other places the falling edge, the pulse width and the pulse delay (phase) can be set independently of each other. The period is still set only by the reload value.

The counter runs in one of two styles. In edge-aligned counting it ramps from 0 up to the reload value and wraps. In center-aligned counting it ramps up to the reload value and then back down to 0. The reload value, both compare values and the counting style are double-buffered. Each mode code arrives split into a lone top bit and a separate three-bit low part, and the block joins the two parts before decoding them. The raw reference and the combined signal of each channel are available as registered outputs.

Top module: `cpwm_pair`

## Requirements
- R1: In edge-aligned counting (`center_mode`=0) the counter steps 0,1,...,A and then returns to 0, so one period is A+1 cycles, where A is the active reload value.
- R2: In center-aligned counting (`center_mode`=1) the counter steps 0,1,...,A,A-1,...,1 and then returns to 0, so one period is 2A cycles (A=1 gives 0,1 and A=0 holds 0). Compare decisions are made the same way on the rising and the falling slope.
- R3: A channel whose code is 4'b0110 drives its raw reference high exactly while counter < compare. Code 4'b0111 drives the inverse. In both plain codes the combined output equals the channel's own raw reference.
- R4: Code 4'b1100 gives the raw reference the 4'b0110 polarity, and the combined output is the OR of this channel's raw reference and the partner channel's raw reference.
- R5: Code 4'b1101 gives the raw reference the 4'b0111 polarity, and the combined output is the AND of this channel's raw reference and the partner channel's raw reference.
- R6: The mode code is {top bit, low three bits}, where the top-bit input is code bit 3. Any code other than 0110, 0111, 1100 and 1101 holds both that channel's raw reference and its combined output low.
- R7: Compare value 0 gives a reference that never goes high under the 0110 polarity. A compare value above the reload value gives a reference that is high for the whole period under that polarity.
- R8: New reload, compare and counting-style inputs take effect only on the clock edge that returns the counter to 0 at the end of a period. Reset loads them directly.
- R9: Outputs are registered. The value seen after a clock edge reflects the counter value held before that edge. While reset is asserted, every output is low and the counter is at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| center_mode | input | 1 | 0 = edge-aligned counting, 1 = center-aligned counting (buffered) |
| reload | input | CNT_W | Period reload value (buffered) |
| cmp_a | input | CNT_W | Compare value of channel A (buffered) |
| cmp_b | input | CNT_W | Compare value of channel B (buffered) |
| mode_lo_a | input | 3 | Channel A mode code bits 2:0 |
| mode_hi_a | input | 1 | Channel A mode code bit 3 |
| mode_lo_b | input | 3 | Channel B mode code bits 2:0 |
| mode_hi_b | input | 1 | Channel B mode code bit 3 |
| ref_out | output | 2 | Raw reference per channel, bit 0 = A, bit 1 = B |
| comb_out | output | 2 | Combined output per channel, bit 0 = A, bit 1 = B |

## Verification
The counter properties assume that the buffered reload value is never below the counter. That holds because buffers are loaded only when the counter returns to 0, and the stimulus never drives the reload input with reset asserted mid-period. The properties on the combining logic assume that mode codes change only on the falling clock edge, so the code sampled at one edge is the code that shaped the outputs registered at that edge. The bench keeps to this by driving every input at the falling edge. Mid-period changes to the reload and compare inputs are made on purpose so that the buffering is exercised, while the mode codes are changed only between scenarios.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  localparam logic [3:0] CODE_PWM_LO   = 4'b0110;
  localparam logic [3:0] CODE_PWM_HI   = 4'b0111;
  localparam logic [3:0] CODE_CMB_OR   = 4'b1100;
  localparam logic [3:0] CODE_CMB_AND  = 4'b1101;

  // decoded channel configuration
  typedef struct packed {
    logic on;       // channel produces a waveform
    logic inv;      // active while counter >= compare
    logic cmb;      // merge with partner reference
    logic use_and;  // merge operator: 1 = AND, 0 = OR
  } ch_cfg_t;

  function automatic ch_cfg_t decode_mode(input logic [3:0] code);
    ch_cfg_t r;
    r = '0;
    case (code)
      CODE_PWM_LO:  r.on = 1'b1;
      CODE_PWM_HI:  begin r.on = 1'b1; r.inv = 1'b1; end
      CODE_CMB_OR:  begin r.on = 1'b1; r.cmb = 1'b1; end
      CODE_CMB_AND: begin r.on = 1'b1; r.inv = 1'b1; r.cmb = 1'b1; r.use_and = 1'b1; end
      default:      r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             center_in,
  input  logic [CNT_W-1:0] reload_in,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] arr_sh,
  output logic             ctr_sh,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, arr_q;
  logic             dn_q, ctr_q;

  // end-of-period detection: next counter value is 0
  always_comb begin
    if (!ctr_q)
      wrap = (cnt_q >= arr_q);
    else if (dn_q)
      wrap = (cnt_q <= ONE);
    else
      wrap = (cnt_q >= arr_q) && (arr_q <= ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
      arr_q <= reload_in;
      ctr_q <= center_in;
    end else if (wrap) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
      arr_q <= reload_in;
      ctr_q <= center_in;
    end else if (!ctr_q) begin
      cnt_q <= cnt_q + ONE;
    end else if (dn_q) begin
      cnt_q <= cnt_q - ONE;
    end else if (cnt_q >= arr_q) begin
      dn_q  <= 1'b1;
      cnt_q <= cnt_q - ONE;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign cnt    = cnt_q;
  assign arr_sh = arr_q;
  assign ctr_sh = ctr_q;
endmodule

// File: rtl/cpwm_chan.sv
module cpwm_chan
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic [CNT_W-1:0] cnt,
  input  ch_cfg_t          cfg,
  output logic             ref_c
);
  logic [CNT_W-1:0] cmp_q;

  // buffered compare value, loaded at period end
  always_ff @(posedge clk) begin
    if (rst || upd) cmp_q <= cmp_in;
  end

  logic below;
  assign below = (cnt < cmp_q);
  assign ref_c = cfg.on & (below ^ cfg.inv);
endmodule

// File: rtl/cpwm_merge.sv
module cpwm_merge
  import cpwm_pkg::*;
(
  input  logic    own_ref,
  input  logic    partner_ref,
  input  ch_cfg_t cfg,
  output logic    comb
);
  always_comb begin
    if (!cfg.on)
      comb = 1'b0;
    else if (!cfg.cmb)
      comb = own_ref;
    else if (cfg.use_and)
      comb = own_ref & partner_ref;
    else
      comb = own_ref | partner_ref;
  end
endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             center_mode,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [2:0]       mode_lo_a,
  input  logic             mode_hi_a,
  input  logic [2:0]       mode_lo_b,
  input  logic             mode_hi_b,
  output logic [1:0]       ref_out,
  output logic [1:0]       comb_out
);
  localparam int NCH = 2;

  logic [CNT_W-1:0] cnt, arr_sh;
  logic             ctr_sh, wrap;

  cpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .center_in(center_mode), .reload_in(reload),
    .cnt(cnt), .arr_sh(arr_sh), .ctr_sh(ctr_sh), .wrap(wrap)
  );

  // reassemble split mode fields
  logic [NCH-1:0][3:0]       code;
  logic [NCH-1:0][CNT_W-1:0] cmp_v;
  ch_cfg_t [NCH-1:0]         cfg;
  logic [NCH-1:0]            ref_c, comb_c;

  assign code[0]  = {mode_hi_a, mode_lo_a};
  assign code[1]  = {mode_hi_b, mode_lo_b};
  assign cmp_v[0] = cmp_a;
  assign cmp_v[1] = cmp_b;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cfg[i] = decode_mode(code[i]);

    cpwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst), .upd(wrap), .cmp_in(cmp_v[i]),
      .cnt(cnt), .cfg(cfg[i]), .ref_c(ref_c[i])
    );

    cpwm_merge u_merge (
      .own_ref(ref_c[i]), .partner_ref(ref_c[NCH-1-i]),
      .cfg(cfg[i]), .comb(comb_c[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_out  <= '0;
      comb_out <= '0;
    end else begin
      ref_out  <= ref_c;
      comb_out <= comb_c;
    end
  end
endmodule

// File: rtl/cpwm_pair_chk.sv
module cpwm_pair_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] arr_sh,
  input logic             ctr_sh,
  input logic             wrap,
  input logic [3:0]       code_a,
  input logic [3:0]       code_b,
  input logic [1:0]       ref_out,
  input logic [1:0]       comb_out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic known_a, known_b;
  assign known_a = (code_a == 4'b0110) || (code_a == 4'b0111) ||
                   (code_a == 4'b1100) || (code_a == 4'b1101);
  assign known_b = (code_b == 4'b0110) || (code_b == 4'b0111) ||
                   (code_b == 4'b1100) || (code_b == 4'b1101);

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= arr_sh);
  p_edge_step_r1: assert property (@(posedge clk) disable iff (rst)
    (!ctr_sh && !wrap) |=> cnt == $past(cnt) + ONE);
  p_center_turn_r2: assert property (@(posedge clk) disable iff (rst)
    (ctr_sh && !wrap && cnt == arr_sh) |=> cnt == $past(cnt) - ONE);
  p_wrap_zero_r8: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cnt == '0);
  p_arr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(arr_sh) && $stable(ctr_sh));
  p_plain_a_r3: assert property (@(posedge clk) disable iff (rst)
    (code_a == 4'b0110 || code_a == 4'b0111) |=> comb_out[0] == ref_out[0]);
  p_plain_b_r3: assert property (@(posedge clk) disable iff (rst)
    (code_b == 4'b0110 || code_b == 4'b0111) |=> comb_out[1] == ref_out[1]);
  p_or_a_r4: assert property (@(posedge clk) disable iff (rst)
    (code_a == 4'b1100) |=> comb_out[0] == (ref_out[0] | ref_out[1]));
  p_or_b_r4: assert property (@(posedge clk) disable iff (rst)
    (code_b == 4'b1100) |=> comb_out[1] == (ref_out[1] | ref_out[0]));
  p_and_a_r5: assert property (@(posedge clk) disable iff (rst)
    (code_a == 4'b1101) |=> comb_out[0] == (ref_out[0] & ref_out[1]));
  p_and_b_r5: assert property (@(posedge clk) disable iff (rst)
    (code_b == 4'b1101) |=> comb_out[1] == (ref_out[1] & ref_out[0]));
  p_off_a_r6: assert property (@(posedge clk) disable iff (rst)
    !known_a |=> !ref_out[0] && !comb_out[0]);
  p_off_b_r6: assert property (@(posedge clk) disable iff (rst)
    !known_b |=> !ref_out[1] && !comb_out[1]);
  p_reset_low_r9: assert property (@(posedge clk)
    rst |=> ref_out == 2'b00 && comb_out == 2'b00 && cnt == '0);
endmodule

bind cpwm_pair cpwm_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .arr_sh(arr_sh), .ctr_sh(ctr_sh),
  .wrap(wrap), .code_a({mode_hi_a, mode_lo_a}), .code_b({mode_hi_b, mode_lo_b}),
  .ref_out(ref_out), .comb_out(comb_out)
);

// File: tb/tb_cpwm_pair.sv
`timescale 1ns/1ps
module tb_cpwm_pair;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             center_mode = 1'b0;
  logic [CNT_W-1:0] reload = '0;
  logic [CNT_W-1:0] cmp_a = '0;
  logic [CNT_W-1:0] cmp_b = '0;
  logic [2:0]       mode_lo_a = 3'b110;
  logic             mode_hi_a = 1'b0;
  logic [2:0]       mode_lo_b = 3'b110;
  logic             mode_hi_b = 1'b0;
  logic [1:0]       ref_out, comb_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  int ph, m_arr, m_ca, m_cb;
  bit m_ctr;

  always #5 clk = ~clk;

  cpwm_pair #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .center_mode(center_mode), .reload(reload),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .mode_lo_a(mode_lo_a), .mode_hi_a(mode_hi_a),
    .mode_lo_b(mode_lo_b), .mode_hi_b(mode_hi_b),
    .ref_out(ref_out), .comb_out(comb_out)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int period_len();
    if (!m_ctr) return m_arr + 1;
    if (m_arr == 0) return 1;
    return 2 * m_arr;
  endfunction

  function automatic int cnt_value();
    if (!m_ctr) return ph;
    return (ph <= m_arr) ? ph : 2 * m_arr - ph;
  endfunction

  function automatic bit ref_exp(input logic [3:0] code, input int cmpv, input int v);
    case (code)
      4'b0110, 4'b1100: return v < cmpv;
      4'b0111, 4'b1101: return !(v < cmpv);
      default:          return 1'b0;
    endcase
  endfunction

  function automatic bit comb_exp(input logic [3:0] code, input bit own, input bit other);
    case (code)
      4'b0110, 4'b0111: return own;
      4'b1100:          return own | other;
      4'b1101:          return own & other;
      default:          return 1'b0;
    endcase
  endfunction

  task automatic load_model();
    m_arr = int'(reload);
    m_ca  = int'(cmp_a);
    m_cb  = int'(cmp_b);
    m_ctr = center_mode;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R9 reset ref", int'(ref_out), 0);
    check("R9 reset comb", int'(comb_out), 0);
    rst = 1'b0;
    ph = 0;
    load_model();
  endtask

  // run n cycles, comparing every cycle against the model
  task automatic run_cycles(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      logic [3:0] ca, cb;
      int v;
      bit ra, rb;
      @(posedge clk);
      @(negedge clk);
      ca = {mode_hi_a, mode_lo_a};
      cb = {mode_hi_b, mode_lo_b};
      v  = cnt_value();
      ra = ref_exp(ca, m_ca, v);
      rb = ref_exp(cb, m_cb, v);
      check({req, " ref"},  int'(ref_out),  int'({rb, ra}));
      check({req, " comb"}, int'(comb_out), int'({comb_exp(cb, rb, ra), comb_exp(ca, ra, rb)}));
      ph++;
      if (ph >= period_len()) begin
        ph = 0;
        load_model();
      end
    end
  endtask

  task automatic set_modes(input logic [3:0] ca, input logic [3:0] cb);
    {mode_hi_a, mode_lo_a} = ca;
    {mode_hi_b, mode_lo_b} = cb;
  endtask

  // R1, R3: edge-aligned plain modes, also one explicit duty count
  task automatic t_edge_plain();
    int highs;
    center_mode = 1'b0; reload = 8'd9; cmp_a = 8'd4; cmp_b = 8'd6;
    set_modes(4'b0110, 4'b0111);
    do_reset();
    run_cycles(25, "R1/R3 edge plain");
    highs = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); @(negedge clk);
      highs += int'(ref_out[0]);
      ph++;
      if (ph >= period_len()) begin ph = 0; load_model(); end
    end
    check("R1 high cycles per 10-cycle period", highs, 4);
  endtask

  // R4, R5: combined modes, shifted pulse
  task automatic t_edge_combined();
    center_mode = 1'b0; reload = 8'd11; cmp_a = 8'd8; cmp_b = 8'd3;
    set_modes(4'b1100, 4'b1101);
    do_reset();
    run_cycles(30, "R4/R5 edge combined");
    cmp_a = 8'd2; cmp_b = 8'd9;
    set_modes(4'b1101, 4'b1100);
    do_reset();
    run_cycles(30, "R4/R5 edge combined swapped");
  endtask

  // R2: center-aligned counting with combined output
  task automatic t_center();
    center_mode = 1'b1; reload = 8'd6; cmp_a = 8'd5; cmp_b = 8'd2;
    set_modes(4'b1101, 4'b1100);
    do_reset();
    run_cycles(30, "R2 center combined");
    reload = 8'd1; cmp_a = 8'd1; cmp_b = 8'd1;
    set_modes(4'b0110, 4'b0111);
    do_reset();
    run_cycles(8, "R2 center reload one");
  endtask

  // R7: compare extremes
  task automatic t_extremes();
    center_mode = 1'b0; reload = 8'd7; cmp_a = 8'd0; cmp_b = 8'd200;
    set_modes(4'b0110, 4'b0110);
    do_reset();
    run_cycles(16, "R7 cmp zero / above reload");
    center_mode = 1'b1; reload = 8'd5;
    do_reset();
    run_cycles(12, "R7 center extremes");
  endtask

  // R8: mid-period changes wait for period end
  task automatic t_preload();
    center_mode = 1'b0; reload = 8'd9; cmp_a = 8'd4; cmp_b = 8'd7;
    set_modes(4'b0110, 4'b0110);
    do_reset();
    run_cycles(3, "R8 before change");
    cmp_a = 8'd8; reload = 8'd5; center_mode = 1'b1;
    run_cycles(4, "R8 old values held");
    run_cycles(30, "R8 new values after wrap");
  endtask

  // R6: split code reassembly and unused codes
  task automatic t_codes();
    center_mode = 1'b0; reload = 8'd7; cmp_a = 8'd3; cmp_b = 8'd5;
    set_modes(4'b0100, 4'b1110);
    do_reset();
    run_cycles(10, "R6 unused codes low");
    set_modes(4'b1100, 4'b0000);
    do_reset();
    run_cycles(10, "R6 top bit set, partner off");
    set_modes(4'b1111, 4'b0101);
    do_reset();
    run_cycles(10, "R6 unused codes low 2");
  endtask

  initial begin
    t_edge_plain();
    t_edge_combined();
    t_center();
    t_extremes();
    t_preload();
    t_codes();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule